// File: doc/BRIEF.md
# Parallel Tree Sum Reducer

This block folds a bank of N word-wide partial sums into one total through a series of halving steps. In each step every addition runs in parallel, and one step completes per clock. The caller presents all N words at once on a flat load bus and pulses `start`. From then on the block walks its halving schedule. When the count of live entries reaches one, the total appears on `total` and `done` pulses.

Two schedules are available, and the `mode` input picks one at launch. The floor schedule halves the live count by truncation. When the count is odd, entry 0 also absorbs the entry that would otherwise be left out. The ceiling schedule halves by rounding up and tracks an upper sender bound. Entries between the new half and that bound pass their value down by half positions, and the receiving entries add it. The bound then shrinks to the new half. Both schedules finish with the total in entry 0. Additions wrap at the word width.

Top module: `tree_sum_reducer`

## Requirements
- R1: After reset `busy`, `done` and `step` are 0 and `total` is 0.
- R2: A `start` sampled while idle loads entry i from `load_data[i*W +: W]`. It latches `mode` (0 = floor schedule, 1 = ceiling schedule) and sets the live count and sender bound to N. On the next cycle `busy` is 1 and `step` is 0.
- R3: Floor schedule, per step, with c the live count: if c is odd, entry 0 adds entry c-1. Then c becomes c/2 rounded down, and each entry i < c adds entry i+c. Every step reads the values from before that step.
- R4: Ceiling schedule, per step: c becomes (c+1)/2. Each entry j with c ≤ j < bound is added into entry j-c, and the bound then becomes c.
- R5: Exactly one step is taken per clock while busy, and `step` counts them. The run ends on the step that leaves c equal to 1. With N = 100 that takes 6 steps under the floor schedule and 7 under the ceiling schedule. With N = 7 it takes 2 and 3 steps.
- R6: `done` is high for exactly one cycle, in the cycle in which `busy` first reads 0. `total` then shows entry 0, which equals the sum of the loaded words, and holds it until the next launch.
- R7: While busy, `start`, `mode` and `load_data` have no effect. The run keeps its timing and its result.
- R8: All additions wrap modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch strobe, accepted only while idle |
| mode | input | 1 | Schedule select: 0 floor, 1 ceiling |
| load_data | input | N*W | Partial sums, entry i at bits i*W upward |
| total | output | W | Entry 0 of the working bank |
| done | output | 1 | One-cycle pulse at the end of a run |
| busy | output | 1 | High while steps are being taken |
| step | output | $clog2(N+1) | Number of steps taken in the current or last run |

## Verification
The checker takes it for granted that `start` stays low for the first two clocks after `rst_n` rises, while the internal reset release is still settling. A launch property would otherwise see a pulse that the block never received. The stimulus holds `start` low for several cycles after reset. It raises `start` only at falling clock edges, and only once `busy` has shown the state the stimulus intends, idle for a launch or busy for a disturbance. The reference model works from the loaded words and the schedule rules alone. It predicts the step on which the run ends and the wrapped total, and it compares `busy`, `done`, `step` and `total` on every clock of each run.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic {
    SCHED_FLOOR = 1'b0,
    SCHED_CEIL  = 1'b1
  } sched_e;
endpackage

// File: rtl/tsr_sched.sv
// Halving schedule: next live count, next sender bound, odd fix-up, last step.
module tsr_sched
  import tsr_pkg::*;
#(
  parameter int HW = 7
) (
  input  logic [HW-1:0] half_q,
  input  logic [HW-1:0] limit_q,
  input  sched_e        mode,
  output logic [HW-1:0] half_nx,
  output logic [HW-1:0] limit_nx,
  output logic          odd_fix,
  output logic          last
);
  logic [HW:0] rounded;

  always_comb begin
    rounded  = {1'b0, half_q} + 1'b1;
    odd_fix  = 1'b0;
    half_nx  = half_q >> 1;
    limit_nx = limit_q;
    if (mode == SCHED_FLOOR) begin
      odd_fix = half_q[0];
    end else begin
      half_nx  = rounded[HW:1];
      limit_nx = rounded[HW:1];
    end
    last = (half_nx == HW'(1));
  end
endmodule

// File: rtl/tsr_lane.sv
// Next value of one bank entry for the current reduction step.
module tsr_lane
  import tsr_pkg::*;
#(
  parameter int N   = 100,
  parameter int W   = 32,
  parameter int HW  = 7,
  parameter int IDX = 0
) (
  input  logic [N-1:0][W-1:0] entries,
  input  logic [HW-1:0]       half_q,
  input  logic [HW-1:0]       half_nx,
  input  logic [HW-1:0]       limit_q,
  input  sched_e              mode,
  input  logic                odd_fix,
  output logic [W-1:0]        nxt
);
  localparam int PW      = HW + 1;
  localparam bit IS_ROOT = (IDX == 0);

  logic [PW-1:0] pidx;
  logic [PW-1:0] fidx;
  logic [W-1:0]  pval;
  logic [W-1:0]  fval;
  logic          take;

  always_comb begin
    pidx = PW'(IDX) + {1'b0, half_nx};
    fidx = {1'b0, half_q} - 1'b1;
    take = (PW'(IDX) < {1'b0, half_nx}) &&
           ((mode == SCHED_FLOOR) || (pidx < {1'b0, limit_q}));
    pval = '0;
    fval = '0;
    for (int k = 0; k < N; k++) begin
      if (pidx == PW'(k)) pval = entries[k];
      if (fidx == PW'(k)) fval = entries[k];
    end
    nxt = entries[IDX];
    if (take) nxt = nxt + pval;
    if (IS_ROOT && odd_fix) nxt = nxt + fval;
  end
endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer
  import tsr_pkg::*;
#(
  parameter int N = 100,
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   mode,
  input  logic [N*W-1:0]         load_data,
  output logic [W-1:0]           total,
  output logic                   done,
  output logic                   busy,
  output logic [$clog2(N+1)-1:0] step
);
  localparam int HW = $clog2(N+1);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      arst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      arst_n   <= rst_meta;
    end
  end

  logic [N-1:0][W-1:0] ent_q, ent_d, lane_nx;
  logic [HW-1:0]       half_q, half_d, half_nx;
  logic [HW-1:0]       limit_q, limit_d, limit_nx;
  logic [HW-1:0]       step_q, step_d;
  logic                busy_q, busy_d, done_q, done_d;
  sched_e              mode_q, mode_d;
  logic                odd_fix, last, launch, en_bank;

  tsr_sched #(.HW(HW)) u_sched (
    .half_q  (half_q),
    .limit_q (limit_q),
    .mode    (mode_q),
    .half_nx (half_nx),
    .limit_nx(limit_nx),
    .odd_fix (odd_fix),
    .last    (last)
  );

  for (genvar g = 0; g < N; g++) begin : g_lane
    tsr_lane #(.N(N), .W(W), .HW(HW), .IDX(g)) u_lane (
      .entries(ent_q),
      .half_q (half_q),
      .half_nx(half_nx),
      .limit_q(limit_q),
      .mode   (mode_q),
      .odd_fix(odd_fix),
      .nxt    (lane_nx[g])
    );
  end

  always_comb begin
    launch  = start && !busy_q;
    en_bank = launch || busy_q;
    ent_d   = launch ? load_data : lane_nx;
    half_d  = launch ? HW'(N) : half_nx;
    limit_d = launch ? HW'(N) : limit_nx;
    step_d  = launch ? '0 : step_q + 1'b1;
    mode_d  = sched_e'(mode);
    busy_d  = launch || (busy_q && !last);
    done_d  = busy_q && last;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ent_q   <= '0;
      half_q  <= '0;
      limit_q <= '0;
      step_q  <= '0;
      mode_q  <= SCHED_FLOOR;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (en_bank) begin
        ent_q   <= ent_d;
        half_q  <= half_d;
        limit_q <= limit_d;
        step_q  <= step_d;
      end
      if (launch) mode_q <= mode_d;
    end
  end

  assign total = ent_q[0];
  assign done  = done_q;
  assign busy  = busy_q;
  assign step  = step_q;
endmodule

// File: rtl/tsr_chk.sv
module tsr_chk #(
  parameter int N  = 100,
  parameter int W  = 32,
  parameter int HW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [HW-1:0] step,
  input logic [W-1:0]  total
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && step == '0));
  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (step == $past(step) + 1'b1));
  // R7
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (step != '0));
  // R6
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(total));
endmodule

bind tree_sum_reducer tsr_chk #(.N(N), .W(W), .HW(HW)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .busy (busy),
  .done (done),
  .step (step),
  .total(total)
);

// File: tb/tree_sum_reducer_tb.sv
module tree_sum_reducer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0, mode = 1'b0;
  logic [31:0] data [100];
  logic [100*32-1:0] load_a;
  logic [7*8-1:0]    load_b;
  logic [31:0] tot_a;
  logic [7:0]  tot_b;
  logic done_a, done_b, busy_a, busy_b;
  logic [6:0] step_a;
  logic [2:0] step_b;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 100; i++) load_a[i*32 +: 32] = data[i];
    for (int i = 0; i < 7; i++) load_b[i*8 +: 8] = data[i][7:0];
  end

  tree_sum_reducer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_a), .mode(mode), .load_data(load_a),
    .total(tot_a), .done(done_a), .busy(busy_a), .step(step_a));

  tree_sum_reducer #(.N(7), .W(8)) u_odd (
    .clk(clk), .rst_n(rst_n), .start(start_b), .mode(mode), .load_data(load_b),
    .total(tot_b), .done(done_b), .busy(busy_b), .step(step_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // schedule length from the halving rules only
  function automatic int nsteps(input int n, input bit ceil_md);
    int h = n;
    int c = 0;
    do begin
      h = ceil_md ? (h + 1) / 2 : h / 2;
      c++;
    end while (h != 1);
    return c;
  endfunction

  task automatic run(input bit sel, input bit md, input bit disturb, input string req);
    int n = sel ? 7 : 100;
    int s = nsteps(n, md);
    longint unsigned acc = 0;
    longint unsigned exp;
    for (int i = 0; i < n; i++) acc += sel ? data[i][7:0] : data[i];
    exp = sel ? (acc & 64'hFF) : (acc & 64'hFFFF_FFFF);
    @(negedge clk);
    mode = md;
    if (sel) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    chk((sel ? busy_b : busy_a) == 1'b1, "R2 busy after launch", sel ? busy_b : busy_a, 1);
    chk((sel ? step_b : step_a) == 0, "R2 step zero", sel ? step_b : step_a, 0);
    for (int j = 1; j <= s + 1; j++) begin
      if (disturb && j == 1) begin
        if (sel) start_b = 1'b1; else start_a = 1'b1;
        mode = ~md;
        for (int i = 0; i < 100; i++) data[i] = ~data[i];
      end else if (disturb && j == 2) begin
        start_a = 1'b0; start_b = 1'b0; mode = md;
      end
      @(negedge clk);
      begin
        longint st = sel ? step_b : step_a;
        longint dn = sel ? done_b : done_a;
        longint bs = sel ? busy_b : busy_a;
        longint tt = sel ? tot_b : tot_a;
        if (j <= s) begin
          chk(st == j, "R5 step count", st, j);
          chk(dn == (j == s), "R6 done timing", dn, j == s);
          chk(bs == (j < s), "R5 busy span", bs, j < s);
          if (j == s) chk(tt == exp, req, tt, exp);
        end else begin
          chk(dn == 0, "R6 done one cycle", dn, 0);
          chk(tt == exp, "R6 total held", tt, exp);
        end
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100; i++) data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy_a == 0 && busy_b == 0, "R1 busy", busy_a | busy_b, 0);
    chk(done_a == 0 && done_b == 0, "R1 done", done_a | done_b, 0);
    chk(step_a == 0 && step_b == 0, "R1 step", step_a | step_b, 0);
    chk(tot_a == 0 && tot_b == 0, "R1 total", tot_a | tot_b, 0);

    for (int i = 0; i < 100; i++) data[i] = $urandom;
    run(0, 0, 0, "R3 floor total N=100");
    for (int i = 0; i < 100; i++) data[i] = $urandom;
    run(0, 1, 0, "R4 ceiling total N=100");
    for (int i = 0; i < 100; i++) data[i] = i + 1;
    run(1, 0, 0, "R3 floor total N=7 odd halves");
    run(1, 1, 0, "R4 ceiling total N=7");
    for (int i = 0; i < 100; i++) data[i] = 32'hFFFF_FFFF;
    run(1, 0, 0, "R8 wrap N=7 floor");
    run(0, 1, 0, "R8 wrap N=100 ceiling");
    for (int i = 0; i < 100; i++) data[i] = $urandom;
    run(0, 0, 1, "R7 disturbed floor N=100");
    for (int i = 0; i < 100; i++) data[i] = $urandom;
    run(1, 1, 1, "R7 disturbed ceiling N=7");
    for (int i = 0; i < 100; i++) data[i] = $urandom;
    run(1, 0, 1, "R7 disturbed floor N=7");
    run(0, 1, 1, "R7 disturbed ceiling N=100");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule